// File: doc/BRIEF.md
# SDH Regenerator Section Receive Checker

This block sits at the receive end of a synchronous optical link. It takes a byte-wide stream that is already octet aligned but has no known frame phase, and carries STM-N frames, where N is a parameter with a default of 16. It locates the frame by searching for a six-byte slice of the framing word. It confirms the frame phase before it reports the link as in frame. Once the phase is known, it removes the frame-synchronous scrambling from every byte outside the first overhead row.

The block also keeps a bitwise even parity over each complete frame as it arrives, while that frame is still scrambled. It checks this parity against the section parity byte carried in the following frame, after that byte has been descrambled. Downstream logic receives the cleaned byte stream with a start-of-frame strobe and an in-frame level. For each frame whose parity byte disagrees, it also receives a one-cycle errored-block pulse together with the number of disagreeing bit positions.

Frame geometry is fixed by N. A frame is 2430·N bytes, the first overhead row is 9·N bytes, and the parity byte sits at byte index 270·N, which is row 2, column 0. Byte index 0 is the first framing byte.

Top module: `rs_rx_section`

## Requirements
- R1: While reset is high, and in the cycle after it, in_frame, out_sof and b1_err are low, b1_err_bits is 0 and out_data is 0.
- R2: While searching, the six consecutive bytes F6 F6 F6 28 28 28 set the frame phase so that the last 28 of the run is byte index 3·N+2 of the frame.
- R3: in_frame rises when the pattern is found again exactly one frame length after the first detection. The rise appears together with the output of the confirming byte.
- R4: If the pattern is absent at the confirmation position, the block goes back to searching, in_frame stays low and descrambling stops.
- R5: While in frame, up to three consecutive frames without the pattern at its expected position leave in_frame high. The fourth consecutive miss clears in_frame with the output of that frame's byte 3·N+2. A frame with the pattern resets the miss count.
- R6: out_sof is high for exactly one cycle, together with the output of byte 0 of each frame that starts while in frame.
- R7: out_data is the input byte delayed by one cycle. Once the phase is known, bytes 0 to 9·N-1 pass unchanged. Every later byte is XORed with a key from the generator x^7+x^6+1, which is seeded to all ones at byte 9·N and shifted most significant bit first, so the first key byte is FE.
- R8: While searching, out_data equals the input byte from one cycle earlier, unchanged.
- R9: While in frame, the descrambled byte at index 270·N is compared bit by bit with the XOR of all bytes of the previous frame as received, still scrambled. On any mismatch, b1_err pulses for one cycle with the output of that byte, and b1_err_bits gives the number of mismatching bits, from 1 to 8.
- R10: No parity check is made in the frame in which in_frame rises, because no complete previous frame with a known phase exists yet.
- R11: When the parity byte matches, b1_err stays low and b1_err_bits is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Received byte, octet aligned, frame phase unknown |
| out_data | output | 8 | Descrambled byte, one cycle after its input |
| out_sof | output | 1 | Marks byte 0 of a frame while in frame |
| in_frame | output | 1 | Frame alignment confirmed |
| b1_err | output | 1 | One-cycle errored-block pulse from the section parity check |
| b1_err_bits | output | 4 | Number of mismatching parity bits, valid with b1_err |

## Verification
A wrong frame position or a wrong alignment state shows at the ports within a single byte after the framing row. The descrambler key then falls on the wrong bytes, so every payload byte on out_data is wrong, and in_frame rises or falls in a cycle other than the one the requirements fix. A corrupt parity accumulator or a stale previous-frame value only shows at the next parity byte, up to one frame later: b1_err pulses on a clean frame, or the bit count differs from the number of bits the bench flipped. The bench therefore compares every output byte of every frame and deliberately flips chosen parity bits.

// File: rtl/rs_rx_pkg.sv
package rs_rx_pkg;

    // Slice of the framing word used for phase search: three A1 then three A2
    localparam int            SYNC_LEN  = 6;
    localparam logic [47:0]   SYNC_WORD = 48'hF6F6F6_282828;
    localparam logic [6:0]    KEY_SEED  = 7'h7F;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_CONFIRM,
        ST_LOCKED
    } align_state_e;

    // Per-byte position information produced by the framer
    typedef struct packed {
        logic phase_known;
        logic in_frame;
        logic first_row;
        logic seed_now;
        logic frame_first;
        logic frame_last;
        logic at_b1;
    } frame_tag_t;

    // Key byte for one byte time, generator x^7+x^6+1, MSB first
    function automatic logic [7:0] key_byte(input logic [6:0] st);
        logic [6:0] s;
        logic [7:0] k;
        s = st;
        k = '0;
        for (int b = 7; b >= 0; b--) begin
            k[b] = s[6];
            s    = {s[5:0], s[6] ^ s[5]};
        end
        return k;
    endfunction

    // Generator state after eight shifts
    function automatic logic [6:0] key_advance(input logic [6:0] st);
        logic [6:0] s;
        s = st;
        for (int b = 0; b < 8; b++) begin
            s = {s[5:0], s[6] ^ s[5]};
        end
        return s;
    endfunction

    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] c;
        c = '0;
        for (int b = 0; b < 8; b++) begin
            c = c + {3'b000, v[b]};
        end
        return c;
    endfunction

endpackage

// File: rtl/rs_frame_locator.sv
module rs_frame_locator
    import rs_rx_pkg::*;
#(
    parameter int N          = 16,
    parameter int OOF_MISSES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    output frame_tag_t tag
);
    localparam int FRAME_LEN = 2430 * N;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int PAT_END   = 3 * N + 2;
    localparam int ROW1      = 9 * N;
    localparam int B1_POS    = 270 * N;
    localparam int MISS_W    = $clog2(OOF_MISSES);
    localparam int HIST_W    = 8 * (SYNC_LEN - 1);

    logic [HIST_W-1:0]   hist;
    logic [8*SYNC_LEN-1:0] cand;
    logic [SYNC_LEN-1:0] byte_hit;
    logic                match;

    logic [POS_W-1:0]    pos, pos_nxt;
    align_state_e        state, state_nxt;
    logic [MISS_W-1:0]   miss, miss_nxt;
    logic                at_pat_end, at_last;

    assign cand = {hist, in_data};

    for (genvar g = 0; g < SYNC_LEN; g++) begin : g_cmp
        assign byte_hit[g] = (cand[8*g +: 8] == SYNC_WORD[8*g +: 8]);
    end
    assign match = &byte_hit;

    assign at_pat_end = (pos == POS_W'(PAT_END));
    assign at_last    = (pos == POS_W'(FRAME_LEN - 1));

    always_comb begin
        state_nxt = state;
        miss_nxt  = miss;
        pos_nxt   = at_last ? '0 : pos + 1'b1;
        case (state)
            ST_HUNT: begin
                if (match) begin
                    state_nxt = ST_CONFIRM;
                    pos_nxt   = POS_W'(PAT_END + 1);
                    miss_nxt  = '0;
                end
            end
            ST_CONFIRM: begin
                if (at_pat_end) begin
                    state_nxt = match ? ST_LOCKED : ST_HUNT;
                    miss_nxt  = '0;
                end
            end
            ST_LOCKED: begin
                if (at_pat_end) begin
                    if (match) begin
                        miss_nxt = '0;
                    end else if (miss == MISS_W'(OOF_MISSES - 1)) begin
                        state_nxt = ST_HUNT;
                        miss_nxt  = '0;
                    end else begin
                        miss_nxt = miss + 1'b1;
                    end
                end
            end
            default: state_nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            pos   <= '0;
            state <= ST_HUNT;
            miss  <= '0;
        end else begin
            hist  <= {hist[HIST_W-9:0], in_data};
            pos   <= pos_nxt;
            state <= state_nxt;
            miss  <= miss_nxt;
        end
    end

    always_comb begin
        tag.phase_known = (state != ST_HUNT);
        tag.in_frame    = (state == ST_LOCKED);
        tag.first_row   = (pos < POS_W'(ROW1));
        tag.seed_now    = (pos == POS_W'(ROW1));
        tag.frame_first = (pos == '0);
        tag.frame_last  = at_last;
        tag.at_b1       = (pos == POS_W'(B1_POS));
    end

endmodule

// File: rtl/rs_descrambler.sv
module rs_descrambler
    import rs_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  frame_tag_t tag,
    output logic [7:0] clear_byte
);
    logic [6:0] lfsr;
    logic [6:0] cur_state;
    logic       active;

    assign cur_state  = tag.seed_now ? KEY_SEED : lfsr;
    assign active     = tag.phase_known && !tag.first_row;
    assign clear_byte = active ? (in_data ^ key_byte(cur_state)) : in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr <= KEY_SEED;
        end else if (tag.phase_known) begin
            lfsr <= key_advance(cur_state);
        end
    end

endmodule

// File: rtl/rs_b1_monitor.sv
module rs_b1_monitor
    import rs_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic [7:0] clear_byte,
    input  frame_tag_t tag,
    output logic       b1_err,
    output logic [3:0] b1_err_bits
);
    logic [7:0] acc;
    logic [7:0] prev_par;
    logic       started;
    logic       par_valid;
    logic [7:0] diff;

    assign diff = clear_byte ^ prev_par;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            prev_par  <= '0;
            started   <= 1'b0;
            par_valid <= 1'b0;
        end else begin
            acc <= tag.frame_first ? in_data : (acc ^ in_data);
            if (!tag.phase_known) begin
                started   <= 1'b0;
                par_valid <= 1'b0;
            end else begin
                if (tag.frame_first) begin
                    started <= 1'b1;
                end
                if (tag.frame_last && started) begin
                    prev_par  <= acc ^ in_data;
                    par_valid <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b1_err      <= 1'b0;
            b1_err_bits <= '0;
        end else if (tag.in_frame && par_valid && tag.at_b1) begin
            b1_err      <= |diff;
            b1_err_bits <= ones8(diff);
        end else begin
            b1_err      <= 1'b0;
            b1_err_bits <= '0;
        end
    end

endmodule

// File: rtl/rs_rx_section.sv
module rs_rx_section
    import rs_rx_pkg::*;
#(
    parameter int N          = 16,
    parameter int OOF_MISSES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       in_frame,
    output logic       b1_err,
    output logic [3:0] b1_err_bits
);
    frame_tag_t tag;
    logic [7:0] clear_byte;
    logic       phase_known;

    rs_frame_locator #(.N(N), .OOF_MISSES(OOF_MISSES)) locator_i (
        .clk     (clk),
        .rst     (rst),
        .in_data (in_data),
        .tag     (tag)
    );

    rs_descrambler descr_i (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .tag        (tag),
        .clear_byte (clear_byte)
    );

    rs_b1_monitor b1_i (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .clear_byte  (clear_byte),
        .tag         (tag),
        .b1_err      (b1_err),
        .b1_err_bits (b1_err_bits)
    );

    assign phase_known = tag.phase_known;
    assign in_frame    = tag.in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_sof  <= 1'b0;
        end else begin
            out_data <= clear_byte;
            out_sof  <= tag.in_frame && tag.frame_first;
        end
    end

endmodule

// File: rtl/rs_rx_section_chk.sv
module rs_rx_section_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] in_data,
    input logic [7:0] out_data,
    input logic       out_sof,
    input logic       in_frame,
    input logic       b1_err,
    input logic [3:0] b1_err_bits,
    input logic       phase_known
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: outputs quiet after a reset edge
    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            a_r1_reset_state: assert (!in_frame && !out_sof && !b1_err && b1_err_bits == 4'd0);
        end
    end

    // R8: no phase known means plain one-cycle pass-through
    a_r8_hunt_passthrough: assert property (@(posedge clk) disable iff (rst)
        !phase_known |=> out_data == $past(in_data));

    // R6: frame strobe only while in frame, never two in a row
    a_r6_sof_in_frame: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> in_frame);
    a_r6_sof_single: assert property (@(posedge clk) disable iff (rst)
        out_sof |=> !out_sof);

    // R9: error pulse is one cycle wide and carries a nonzero count
    a_r9_err_single: assert property (@(posedge clk) disable iff (rst)
        b1_err |=> !b1_err);
    a_r9_err_count: assert property (@(posedge clk) disable iff (rst)
        b1_err |-> (b1_err_bits != 4'd0 && b1_err_bits <= 4'd8));

    // R11: no count without a pulse
    a_r11_quiet_count: assert property (@(posedge clk) disable iff (rst)
        !b1_err |-> b1_err_bits == 4'd0);

    // R10: parity errors only reported while in frame
    a_r10_err_in_frame: assert property (@(posedge clk) disable iff (rst)
        b1_err |-> in_frame);

endmodule

bind rs_rx_section rs_rx_section_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_data     (in_data),
    .out_data    (out_data),
    .out_sof     (out_sof),
    .in_frame    (in_frame),
    .b1_err      (b1_err),
    .b1_err_bits (b1_err_bits),
    .phase_known (phase_known)
);

// File: tb/rs_rx_section_tb_top.sv
module rs_rx_section_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 1;
    localparam int FL         = 2430 * N;
    localparam int ROW1       = 9 * N;
    localparam int PAT_END    = 3 * N + 2;
    localparam int B1_POS     = 270 * N;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic [7:0] out_data;
    logic       out_sof, in_frame, b1_err;
    logic [3:0] b1_err_bits;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic       e_valid = 0;
    logic [7:0] e_data;
    logic       e_sof, e_inf, e_err;
    logic [3:0] e_cnt;
    string      e_dreq, e_ireq, e_breq;
    logic [7:0] prev_par = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_rx_section #(.N(N), .OOF_MISSES(4)) dut_i (
        .clk(clk), .rst(rst), .in_data(in_data),
        .out_data(out_data), .out_sof(out_sof), .in_frame(in_frame),
        .b1_err(b1_err), .b1_err_bits(b1_err_bits)
    );

    function automatic logic [3:0] bits_set(input logic [7:0] v);
        int c = 0;
        for (int b = 0; b < 8; b++) c += int'(v[b]);
        return 4'(c);
    endfunction

    task automatic chk1(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_prev();
        if (e_valid) begin
            chk1(e_dreq, "out_data", int'(out_data), int'(e_data));
            chk1(e_ireq, "in_frame", int'(in_frame), int'(e_inf));
            chk1("R6", "out_sof", int'(out_sof), int'(e_sof));
            chk1(e_breq, "b1_err", int'(b1_err), int'(e_err));
            chk1(e_breq, "b1_err_bits", int'(b1_err_bits), int'(e_cnt));
        end
    endtask

    task automatic push(input logic [7:0] raw, input logic [7:0] ed, input logic es,
                        input logic ei, input logic ee, input logic [3:0] ec,
                        input string dreq, input string ireq, input string breq);
        @(negedge clk);
        check_prev();
        in_data = raw;
        e_valid = 1; e_data = ed; e_sof = es; e_inf = ei; e_err = ee; e_cnt = ec;
        e_dreq = dreq; e_ireq = ireq; e_breq = breq;
    endtask

    // One frame; flags give the expected port behaviour from the requirements
    task automatic send_frame(input int f, input bit bad, input logic [7:0] mask,
                              input bit inf_lo, input bit inf_hi, input bit desc,
                              input bit sof_e, input bit chk,
                              input string dreq, input string ireq, input string breq);
        logic [7:0] par = 8'h00;
        logic [6:0] st = 7'h7F;
        for (int i = 0; i < FL; i++) begin
            logic [7:0] plain, key, raw, ed;
            logic ee;
            if (i < 3 * N)        plain = (bad && i == 2) ? 8'h00 : 8'hF6;
            else if (i < 6 * N)   plain = 8'h28;
            else if (i < ROW1)    plain = 8'(8'h11 * i);
            else if (i == B1_POS) plain = prev_par ^ mask;
            else                  plain = 8'((i * 29 + f * 53 + 7) & 255);
            key = 8'h00;
            if (i >= ROW1) begin
                for (int b = 7; b >= 0; b--) begin
                    key[b] = st[6];
                    st = {st[5:0], st[6] ^ st[5]};
                end
            end
            raw = plain ^ key;
            par = par ^ raw;
            ed  = (i >= ROW1 && !desc) ? raw : plain;
            ee  = chk && (i == B1_POS) && (mask != 8'h00);
            push(raw, ed, (i == 0) && sof_e, (i < PAT_END) ? inf_lo : inf_hi,
                 ee, ee ? bits_set(mask) : 4'd0,
                 (i >= ROW1 && desc) ? dreq : "R8", ireq, breq);
        end
        prev_par = par;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk1("R1", "in_frame in reset", int'(in_frame), 0);
        chk1("R1", "b1_err in reset", int'(b1_err), 0);
        @(negedge clk);
        rst = 1'b0;
        chk1("R1", "out_sof after reset", int'(out_sof), 0);
        chk1("R1", "out_data after reset", int'(out_data), 0);
        chk1("R1", "b1_err_bits after reset", int'(b1_err_bits), 0);

        // R8: unaligned filler passes through unchanged
        for (int i = 0; i < 700; i++) push(8'h5A, 8'h5A, 0, 0, 0, 4'd0, "R8", "R3", "R11");

        // R2 first detection, R3 confirmation, R10 first frame unchecked
        send_frame(0,  0, 8'h00, 0, 0, 1, 0, 0, "R2", "R3", "R10");
        send_frame(1,  0, 8'hFF, 0, 1, 1, 0, 0, "R7", "R3", "R10");
        // R11 clean parity, R9 flipped bits
        send_frame(2,  0, 8'h00, 1, 1, 1, 1, 1, "R7", "R3", "R11");
        send_frame(3,  0, 8'h05, 1, 1, 1, 1, 1, "R7", "R3", "R9");
        send_frame(4,  0, 8'hFF, 1, 1, 1, 1, 1, "R7", "R3", "R9");
        // R5: three misses, one hit, then four misses
        for (int f = 5; f < 8; f++) send_frame(f, 1, 8'h00, 1, 1, 1, 1, 1, "R7", "R5", "R11");
        send_frame(8,  0, 8'h00, 1, 1, 1, 1, 1, "R7", "R5", "R11");
        for (int f = 9; f < 12; f++) send_frame(f, 1, 8'h00, 1, 1, 1, 1, 1, "R7", "R5", "R11");
        send_frame(12, 1, 8'h00, 1, 0, 0, 1, 0, "R8", "R5", "R11");
        // R2 relock, R4 failed confirmation
        send_frame(13, 0, 8'h00, 0, 0, 1, 0, 0, "R2", "R4", "R11");
        send_frame(14, 1, 8'h00, 0, 0, 0, 0, 0, "R4", "R4", "R11");
        send_frame(15, 0, 8'h00, 0, 0, 1, 0, 0, "R2", "R3", "R11");
        send_frame(16, 0, 8'h3C, 0, 1, 1, 0, 0, "R7", "R3", "R10");
        send_frame(17, 0, 8'h80, 1, 1, 1, 1, 1, "R7", "R3", "R9");
        send_frame(18, 0, 8'h00, 1, 1, 1, 1, 1, "R7", "R3", "R11");
        @(negedge clk);
        check_prev();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule